// File: doc/BRIEF.md
# Low-Power DDR Wake-Up Command Sequencer

This block drives the command, bank and address pins of a low-power DDR memory. It takes the memory from power-on or deep power-down to idle. A single start pulse begins the sequence. Clock enable goes high and stays high. Only deselect cycles appear on the bus for a long settling pause. A precharge-all command follows, then a row-precharge wait. After that come three steps: a configurable number of auto-refresh commands, a mode register write and an extended mode register write. A set wait follows each command before the next one. When the last wait has run out, a ready flag tells the controller that normal traffic may begin.

The extended mode register word is assembled from two small fields: an output driver strength and a partial-array self-refresh region. Reserved region codes fall back to refreshing the whole array. The order of the three post-precharge steps is chosen by a 3-bit input. Every wait is a clock-count parameter fixed at elaboration.

Top module: `lpddr_wake_seq`

## Requirements
- R1: After reset, and until the first start pulse, cke is 0, ready is 0 and the bus shows deselect (cs_n, ras_n, cas_n, we_n all 1, ba and addr all 0).
- R2: A start sampled at clock edge E drives cke to 1 from edge E onward, and cke never drops again before reset. Edges E to E+PAUSE_CYC-1 carry only deselect. Edge E+PAUSE_CYC carries precharge-all: cs_n=0, ras_n=0, cas_n=1, we_n=0, addr bit 10 = 1, all other addr bits and ba = 0.
- R3: The first post-precharge command appears exactly TRP_CYC clocks after the precharge.
- R4: The refresh step issues exactly REF_CNT auto-refresh commands (cs_n=0, ras_n=0, cas_n=0, we_n=1, ba=0, addr=0). They are TRFC_CYC clocks apart, and the command after the last one follows TRFC_CYC clocks later. REF_CNT is at least 2.
- R5: The mode register write is cs_n=ras_n=cas_n=we_n=0 with ba=00 and addr equal to mode_word. The next command, or ready, follows TMRD_CYC clocks later, and TMRD_CYC is at least 2.
- R6: The extended mode register write uses the same command pins with ba=10. addr[6:5] carries drv_sel (00 full, 01 half, 10 quarter, 11 eighth strength). addr[2:0] carries the refresh region (000 whole array, 001 banks 0 and 1, 010 bank 0). Every other addr bit is 0, and TMRD_CYC clocks follow before the next event.
- R7: A pasr_sel value of 3 to 7 is written as 000 in addr[2:0].
- R8: order_sel picks the step order, with Refresh = F, mode register = M and extended mode register = X. The codes are 0: F,M,X; 1: F,X,M; 2: M,F,X; 3: M,X,F; 4: X,F,M; 5: X,M,F. Codes 6 and 7 behave as 0.
- R9: ready rises exactly one wait period (TRFC_CYC or TMRD_CYC, by the kind of the last command) after the last command. It stays 1 with the bus deselected until a new start.
- R10: A start pulse while a sequence is running is ignored and leaves the command timeline unchanged. A start while ready restarts the whole sequence.
- R11: Every clock in the sequence that carries no command shows deselect with ba and addr at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the wake-up sequence (accepted when idle or ready) |
| mode_word | input | ADDR_W | Value written to the mode register |
| drv_sel | input | 2 | Output driver strength code |
| pasr_sel | input | 3 | Self-refresh array region code |
| order_sel | input | 3 | Order of refresh and the two register writes |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | ADDR_W | Address bus |
| ready | output | 1 | Sequence complete, memory idle |

## Verification
The bench sweeps all eight order codes, all driver codes and all region codes. Against each it runs a cycle-by-cycle timeline worked out from the wait lengths. A design that counted one wait short or long would put a command one clock off the expected slot. One that mishandled codes 6 and 7, or the reserved region codes, would emit steps in the wrong order or leak a reserved value into the extended register. Start pulses are injected during the pause and during the step phase. A design that restarted on them would shift every later command. Ready is checked on its exact rising clock after a refresh-final order and after a register-final order, because the two orders end on different waits.

// File: rtl/lpddr_wake_pkg.sv
package lpddr_wake_pkg;

  typedef enum logic [1:0] {
    STEP_REF  = 2'd0,
    STEP_MRS  = 2'd1,
    STEP_EMRS = 2'd2
  } step_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PAUSE = 2'd1,
    ST_GAP   = 2'd2,
    ST_READY = 2'd3
  } seq_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  typedef logic [3:0] cmd_pins_t;
  localparam cmd_pins_t CMD_DESL = 4'b1111;
  localparam cmd_pins_t CMD_PRE  = 4'b0010;
  localparam cmd_pins_t CMD_REF  = 4'b0001;
  localparam cmd_pins_t CMD_MRS  = 4'b0000;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lpddr_emr_fmt.sv
module lpddr_emr_fmt #(
  parameter int ADDR_W = 13
) (
  input  logic [1:0]        drv_sel,
  input  logic [2:0]        pasr_sel,
  output logic [ADDR_W-1:0] emr_word
);

  logic [2:0] region;

  always_comb begin
    region = (pasr_sel <= 3'd2) ? pasr_sel : 3'd0;
    emr_word      = '0;
    emr_word[6:5] = drv_sel;
    emr_word[2:0] = region;
  end

endmodule

// File: rtl/lpddr_step_order.sv
module lpddr_step_order
  import lpddr_wake_pkg::*;
(
  input  logic [2:0]       order_sel,
  output logic [2:0][1:0]  slot_step
);

  logic [2:0] seen;

  always_comb begin
    case (order_sel)
      3'd1:    slot_step = {STEP_MRS,  STEP_EMRS, STEP_REF };
      3'd2:    slot_step = {STEP_EMRS, STEP_REF,  STEP_MRS };
      3'd3:    slot_step = {STEP_REF,  STEP_EMRS, STEP_MRS };
      3'd4:    slot_step = {STEP_MRS,  STEP_REF,  STEP_EMRS};
      3'd5:    slot_step = {STEP_REF,  STEP_MRS,  STEP_EMRS};
      default: slot_step = {STEP_EMRS, STEP_MRS,  STEP_REF };
    endcase
  end

  always_comb begin
    seen = '0;
    for (int i = 0; i < 3; i++) begin
      seen[slot_step[i]] = 1'b1;
    end
    // each step must occupy exactly one slot (R8)
    if (!$isunknown(order_sel)) begin
      assert_order_perm_R8: assert ($countones(seen) == 3);
    end
  end

endmodule

// File: rtl/lpddr_delay_cnt.sv
module lpddr_delay_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/lpddr_wake_seq.sv
module lpddr_wake_seq
  import lpddr_wake_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int PAUSE_CYC = 20000,
  parameter int TRP_CYC   = 3,
  parameter int TRFC_CYC  = 10,
  parameter int TMRD_CYC  = 2,
  parameter int REF_CNT   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] mode_word,
  input  logic [1:0]        drv_sel,
  input  logic [2:0]        pasr_sel,
  input  logic [2:0]        order_sel,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              ready
);

  localparam int GAP_MAX = max2(max2(PAUSE_CYC, TRP_CYC), max2(TRFC_CYC, TMRD_CYC));
  localparam int CNT_W   = $clog2(GAP_MAX + 1);
  localparam int REF_W   = $clog2(REF_CNT + 1);

  seq_state_e        state_q, state_d;
  logic [1:0]        slot_q, slot_d;
  logic [REF_W-1:0]  refs_q, refs_d;
  logic              cke_q, cke_d;
  logic              ready_q, ready_d;
  cmd_pins_t         cmd_q, cmd_d;
  logic [1:0]        ba_q, ba_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_zero;
  logic [ADDR_W-1:0] emr_word;
  logic [2:0][1:0]   slot_step;
  step_e             cur_step;

  lpddr_emr_fmt #(.ADDR_W(ADDR_W)) u_emr (
    .drv_sel  (drv_sel),
    .pasr_sel (pasr_sel),
    .emr_word (emr_word)
  );

  lpddr_step_order u_order (
    .order_sel (order_sel),
    .slot_step (slot_step)
  );

  lpddr_delay_cnt #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_zero)
  );

  always_comb begin
    case (slot_q)
      2'd0:    cur_step = step_e'(slot_step[0]);
      2'd1:    cur_step = step_e'(slot_step[1]);
      default: cur_step = step_e'(slot_step[2]);
    endcase
  end

  // next-state logic
  always_comb begin
    state_d  = state_q;
    slot_d   = slot_q;
    refs_d   = refs_q;
    cke_d    = cke_q;
    ready_d  = ready_q;
    cmd_d    = CMD_DESL;
    ba_d     = '0;
    addr_d   = '0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE, ST_READY: begin
        if (start) begin
          state_d  = ST_PAUSE;
          cke_d    = 1'b1;
          ready_d  = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(PAUSE_CYC - 1);
        end
      end
      ST_PAUSE: begin
        if (tmr_zero) begin
          cmd_d      = CMD_PRE;
          addr_d[10] = 1'b1;
          tmr_load   = 1'b1;
          tmr_val    = CNT_W'(TRP_CYC - 1);
          slot_d     = 2'd0;
          refs_d     = REF_W'(REF_CNT);
          state_d    = ST_GAP;
        end
      end
      ST_GAP: begin
        if (tmr_zero) begin
          if (slot_q == 2'd3) begin
            state_d = ST_READY;
            ready_d = 1'b1;
          end else begin
            tmr_load = 1'b1;
            case (cur_step)
              STEP_REF: begin
                cmd_d   = CMD_REF;
                tmr_val = CNT_W'(TRFC_CYC - 1);
                if (refs_q == REF_W'(1)) begin
                  slot_d = slot_q + 2'd1;
                  refs_d = REF_W'(REF_CNT);
                end else begin
                  refs_d = refs_q - 1'b1;
                end
              end
              STEP_MRS: begin
                cmd_d   = CMD_MRS;
                addr_d  = mode_word;
                tmr_val = CNT_W'(TMRD_CYC - 1);
                slot_d  = slot_q + 2'd1;
              end
              default: begin
                cmd_d   = CMD_MRS;
                ba_d    = 2'b10;
                addr_d  = emr_word;
                tmr_val = CNT_W'(TMRD_CYC - 1);
                slot_d  = slot_q + 2'd1;
              end
            endcase
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      refs_q  <= '0;
      cke_q   <= 1'b0;
      ready_q <= 1'b0;
      cmd_q   <= CMD_DESL;
      ba_q    <= '0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      refs_q  <= refs_d;
      cke_q   <= cke_d;
      ready_q <= ready_d;
      cmd_q   <= cmd_d;
      ba_q    <= ba_d;
      addr_q  <= addr_d;
    end
  end

  assign cke   = cke_q;
  assign ready = ready_q;
  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign ba    = ba_q;
  assign addr  = addr_q;

  // ---------------- checking logic ----------------
  logic [CNT_W:0]   chk_since;
  logic             chk_last_rs;
  logic [REF_W:0]   chk_refs;
  logic             is_rs, is_ref, is_pre;

  assign is_rs  = ({cs_n, ras_n, cas_n, we_n} == CMD_MRS);
  assign is_ref = ({cs_n, ras_n, cas_n, we_n} == CMD_REF);
  assign is_pre = ({cs_n, ras_n, cas_n, we_n} == CMD_PRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_since   <= '1;
      chk_last_rs <= 1'b0;
      chk_refs    <= '0;
    end else begin
      if (!cs_n) begin
        chk_since   <= '0;
        chk_last_rs <= is_rs;
      end else if (chk_since != '1) begin
        chk_since <= chk_since + 1'b1;
      end
      if (is_pre) begin
        chk_refs <= '0;
      end else if (is_ref) begin
        chk_refs <= chk_refs + 1'b1;
      end
    end
  end

  assert_cke_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);

  assert_cmd_needs_cke_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> cke);

  assert_tmrd_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && chk_last_rs) |-> (int'(chk_since) >= TMRD_CYC - 1));

  assert_emr_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rs && ba == 2'b10) |-> (addr[2:0] <= 3'd2 && addr[4:3] == 2'b00
                               && addr[ADDR_W-1:7] == '0));

  assert_ref_total_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (int'(chk_refs) == REF_CNT));

  assert_ready_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> cs_n);

endmodule

// File: tb/test_lpddr_wake_seq.sv
module test_lpddr_wake_seq;

  localparam int AW    = 13;
  localparam int PAUSE = 7;
  localparam int TRP   = 3;
  localparam int TRFC  = 4;
  localparam int TMRD  = 2;
  localparam int NREF  = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [AW-1:0] mode_word;
  logic [1:0]    drv_sel;
  logic [2:0]    pasr_sel;
  logic [2:0]    order_sel;
  logic          cke, cs_n, ras_n, cas_n, we_n, ready;
  logic [1:0]    ba;
  logic [AW-1:0] addr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  lpddr_wake_seq #(
    .ADDR_W(AW), .PAUSE_CYC(PAUSE), .TRP_CYC(TRP),
    .TRFC_CYC(TRFC), .TMRD_CYC(TMRD), .REF_CNT(NREF)
  ) i_lpddr_wake_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_word(mode_word),
    .drv_sel(drv_sel), .pasr_sel(pasr_sel), .order_sel(order_sel),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .ready(ready)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // expected timeline for one run, indexed by edge count since start
  logic [3:0]    e_cmd  [0:63];
  logic [1:0]    e_ba   [0:63];
  logic [AW-1:0] e_addr [0:63];
  string         e_tag  [0:63];
  int            ready_t;

  // step order table from R8: 0 refresh, 1 mode reg, 2 ext mode reg
  function automatic int step_at(input int order, input int slot);
    int tbl [6][3] = '{'{0,1,2}, '{0,2,1}, '{1,0,2}, '{1,2,0}, '{2,0,1}, '{2,1,0}};
    int o = (order > 5) ? 0 : order;
    return tbl[o][slot];
  endfunction

  function automatic logic [20:0] pack_out();
    return {cke, cs_n, ras_n, cas_n, we_n, ba, addr, ready};
  endfunction

  task automatic check_vec(input logic [20:0] exp_v, input string tag, input int c);
    checks++;
    if (pack_out() !== exp_v) begin
      fails++;
      $display("FAIL %s edge %0d: actual %h expected %h", tag, c, pack_out(), exp_v);
    end
  endtask

  task automatic build(input int order, input int drv, input int pasr, input logic [AW-1:0] mw);
    int t;
    logic [AW-1:0] ew;
    for (int i = 0; i < 64; i++) begin
      e_cmd[i] = 4'b1111; e_ba[i] = 2'b00; e_addr[i] = '0;
      e_tag[i] = (i < PAUSE) ? "R2" : "R11";
    end
    e_cmd[PAUSE] = 4'b0010; e_addr[PAUSE] = AW'(1) << 10; e_tag[PAUSE] = "R2";
    t = PAUSE + TRP;
    ew = '0;
    ew[6:5] = 2'(drv);
    ew[2:0] = (pasr <= 2) ? 3'(pasr) : 3'd0;
    for (int s = 0; s < 3; s++) begin
      int st = step_at(order, s);
      if (st == 0) begin
        for (int k = 0; k < NREF; k++) begin
          e_cmd[t] = 4'b0001; e_tag[t] = (order > 5) ? "R8" : "R4";
          t += TRFC;
        end
      end else if (st == 1) begin
        e_cmd[t] = 4'b0000; e_addr[t] = mw; e_tag[t] = (order > 5) ? "R8" : "R5";
        t += TMRD;
      end else begin
        e_cmd[t] = 4'b0000; e_ba[t] = 2'b10; e_addr[t] = ew;
        e_tag[t] = (pasr > 2) ? "R7" : ((order > 5) ? "R8" : "R6");
        t += TMRD;
      end
    end
    e_tag[PAUSE + TRP] = "R3";
    ready_t = t;
  endtask

  task automatic run_seq(input int order, input int drv, input int pasr,
                         input logic [AW-1:0] mw, input int inject_at);
    build(order, drv, pasr, mw);
    order_sel = 3'(order); drv_sel = 2'(drv); pasr_sel = 3'(pasr); mode_word = mw;
    start = 1'b1;
    for (int c = 0; c <= ready_t; c++) begin
      logic [20:0] ev;
      string tg;
      @(posedge clk);
      @(negedge clk);
      start = (inject_at >= 0 && c == inject_at - 1);
      ev = {1'b1, e_cmd[c], e_ba[c], e_addr[c], (c >= ready_t)};
      tg = (c == ready_t) ? "R9" : e_tag[c];
      if (inject_at >= 0 && c >= inject_at) tg = "R10";
      check_vec(ev, tg, c);
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; mode_word = '0; drv_sel = '0;
    pasr_sel = '0; order_sel = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      // R1: idle after reset, cke low, bus deselected
      check_vec({1'b0, 4'b1111, 2'b00, {AW{1'b0}}, 1'b0}, "R1", i);
    end
    // full sweep; R10 injections during pause and during the step phase
    for (int o = 0; o < 8; o++) begin
      for (int d = 0; d < 4; d++) begin
        for (int p = 0; p < 8; p++) begin
          int run = o * 32 + d * 8 + p;
          int inj = -1;
          if (run % 16 == 5) inj = 4;
          if (run % 16 == 9) inj = PAUSE + TRP + 2;
          run_seq(o, d, p, AW'(run * 37 + 5), inj);
        end
      end
    end
    // R9: ready holds, bus quiet while no new start
    start = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check_vec({1'b1, 4'b1111, 2'b00, {AW{1'b0}}, 1'b1}, "R9", i);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule